// File: doc/BRIEF.md
# Precision Time Clock with Step and Rate Correction

This block keeps a running time of day made of a whole-seconds field and a binary sub-seconds field. The time advances through a rate accumulator: every clock the live addend is added into an accumulator, and each carry out of it moves the sub-seconds count up by one. The sub-seconds field wraps to zero after its all-ones value and bumps the seconds field. Because the two fields are kept as one concatenated value, any carry or borrow between them is handled exactly.

Software corrects the time in two ways. A step correction adds a signed offset, or subtracts it, in a single operation. A rate correction stages a new addend, which only goes live on command. Raising the addend makes time run faster and lowering it makes time run slower. Both commands are bits in the control register that clear themselves once applied.

A target-time unit compares the running time with a programmed target. When the time passes the target, it raises a trigger output that is synchronous to the block clock and latches a status flag. The flag drives a maskable interrupt and clears when it is read.

Two state machines do the work:
- Command sequencer. In `CMD_IDLE` it waits, and it moves to `CMD_APPLY` when any command bit is pending. `CMD_APPLY` performs the pending commands in one cycle, clears them, and always returns to `CMD_IDLE`.
- Target unit. From `TGT_DISARMED`, a write of the target sub-seconds goes to `TGT_ARMED`. From `TGT_ARMED`, time strictly above the target goes to `TGT_FIRED`. A write of the target seconds from any state goes to `TGT_DISARMED`, and a write of the target sub-seconds from any state goes to `TGT_ARMED`.

Register addresses (4-bit): 0 control, 1 step seconds, 2 step sub-seconds/sign, 3 staged addend, 4 target seconds, 5 target sub-seconds, 6 time seconds, 7 time sub-seconds, 8 status, 9 live addend. Control bits: bit0 step command, bit1 addend command, bit2 interrupt mask (1 = masked).

Top module: `ptp_clock_corrector`

## Requirements
- R1: Each clock the accumulator adds the live addend, and each carry out of the accumulator increments the sub-seconds field (address 7, bits 30:0). After 0x7FFFFFFF the sub-seconds field wraps to 0 and the seconds field (address 6) increments. An addend of 0 freezes time.
- R2: The step offset is formed from address 1 (seconds) and address 2 bits 30:0 (sub-seconds). Address 2 bit31 set means subtract. Setting control bit0 adds this offset to, or subtracts it from, the concatenated {seconds, sub-seconds} time in one step, with carry and borrow across the two fields.
- R3: Control bit0 and bit1 read back as 1 while pending and read back as 0 once applied, within three clocks of the write.
- R4: Writing the staged addend (address 3) changes neither the live addend (address 9) nor the rate. Setting control bit1 copies the staged value into the live addend.
- R5: When bit0 and bit1 are written together, the step and the addend load are both applied and both bits clear.
- R6: Writing target sub-seconds (address 5) arms the comparator. `trig_out` rises once the time is strictly greater than the target {address 4, address 5}. A time equal to the target does not trigger.
- R7: `trig_out` stays high until a target register is written. A write of the target seconds drops it.
- R8: Status bit0 (address 8) is set when the trigger fires, and it clears when the status register is read.
- R9: `irq` equals status bit0 AND NOT control bit2.
- R10: After reset the time is 0, the live addend is `ADDEND_INIT` (default 0x80000000), the status is 0, the control register is 0, and `trig_out` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 8) |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| trig_out | output | 1 | High once time has passed the armed target |
| irq | output | 1 | Target interrupt after masking |

## Verification
The hardest condition to reach is the sub-seconds rollover into seconds, because at the reset rate it would take about 2^32 clocks to arrive. The stimulus first freezes time with a zero addend. It then uses a step correction to place the time one count below the wrap, reads it back exactly, and releases the half-rate addend for a short window before freezing again. This makes the crossing happen at a known point, and the bench checks the result against a tolerance band. Exact comparisons for step arithmetic and target equality are made only while time is frozen.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

    typedef enum logic {
        CMD_IDLE,
        CMD_APPLY
    } cmd_state_t;

    typedef enum logic [1:0] {
        TGT_DISARMED,
        TGT_ARMED,
        TGT_FIRED
    } tgt_state_t;

    localparam logic [3:0] REG_CTRL         = 4'd0;
    localparam logic [3:0] REG_STEP_SEC     = 4'd1;
    localparam logic [3:0] REG_STEP_SUB     = 4'd2;
    localparam logic [3:0] REG_ADDEND_STAGE = 4'd3;
    localparam logic [3:0] REG_TGT_SEC      = 4'd4;
    localparam logic [3:0] REG_TGT_SUB      = 4'd5;
    localparam logic [3:0] REG_TIME_SEC     = 4'd6;
    localparam logic [3:0] REG_TIME_SUB     = 4'd7;
    localparam logic [3:0] REG_STATUS       = 4'd8;
    localparam logic [3:0] REG_ADDEND_LIVE  = 4'd9;

    localparam int CTRL_STEP_BIT   = 0;
    localparam int CTRL_ADDEND_BIT = 1;
    localparam int CTRL_MASK_BIT   = 2;

endpackage

// File: rtl/ptpc_cmd_fsm.sv
module ptpc_cmd_fsm
    import ptpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic set_step,
    input  logic set_addend,
    output logic step_pend,
    output logic addend_pend,
    output logic do_step,
    output logic do_addend
);

    cmd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:  if (step_pend || addend_pend) state_d = CMD_APPLY;
            CMD_APPLY: state_d = CMD_IDLE;
            default:   state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        do_step   = (state_q == CMD_APPLY) && step_pend;
        do_addend = (state_q == CMD_APPLY) && addend_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_pend   <= 1'b0;
            addend_pend <= 1'b0;
        end else begin
            if (ctrl_wr && set_step)          step_pend   <= 1'b1;
            else if (state_q == CMD_APPLY)    step_pend   <= 1'b0;
            if (ctrl_wr && set_addend)        addend_pend <= 1'b1;
            else if (state_q == CMD_APPLY)    addend_pend <= 1'b0;
        end
    end

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMD_APPLY && !ctrl_wr) |=> (!step_pend && !addend_pend)); // R3

    AST_CMD_BOTH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && set_step && set_addend) |=> (step_pend && addend_pend)); // R5

endmodule

// File: rtl/ptpc_time_core.sv
module ptpc_time_core #(
    parameter int          SEC_W       = 32,
    parameter int          SUB_W       = 31,
    parameter int          ACC_W       = 32,
    parameter logic [31:0] ADDEND_INIT = 32'h8000_0000,
    localparam int         TW          = SEC_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_step,
    input  logic             do_addend,
    input  logic             step_neg,
    input  logic [SEC_W-1:0] step_sec,
    input  logic [SUB_W-1:0] step_sub,
    input  logic [ACC_W-1:0] addend_stage,
    output logic [TW-1:0]    time_q,
    output logic [ACC_W-1:0] addend_q
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;
    logic [TW-1:0]    tick_val;
    logic [TW-1:0]    step_val;
    logic [TW-1:0]    time_d;

    assign acc_sum  = {1'b0, acc_q} + {1'b0, addend_q};
    assign tick_val = time_q + {{(TW-1){1'b0}}, acc_sum[ACC_W]};
    assign step_val = {step_sec, step_sub};

    always_comb begin
        time_d = tick_val;
        if (do_step) begin
            if (step_neg) time_d = tick_val - step_val;
            else          time_d = tick_val + step_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            time_q   <= '0;
            addend_q <= ADDEND_INIT[ACC_W-1:0];
        end else begin
            acc_q  <= acc_sum[ACC_W-1:0];
            time_q <= time_d;
            if (do_addend) addend_q <= addend_stage;
        end
    end

    AST_TIME_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        !do_step |=> (time_q >= $past(time_q))); // R1

    AST_TIME_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !do_step |=> ((time_q - $past(time_q)) <= 1)); // R1

    AST_ADDEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_addend |=> $stable(addend_q)); // R4

endmodule

// File: rtl/ptpc_target_unit.sv
module ptpc_target_unit
    import ptpc_pkg::*;
#(
    parameter int  SEC_W = 32,
    parameter int  SUB_W = 31,
    localparam int TW    = SEC_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    time_now,
    input  logic             tgt_sec_wr,
    input  logic             tgt_sub_wr,
    input  logic [SEC_W-1:0] tgt_sec_in,
    input  logic [SUB_W-1:0] tgt_sub_in,
    input  logic             status_rd,
    input  logic             irq_mask,
    output logic [SEC_W-1:0] tgt_sec_q,
    output logic [SUB_W-1:0] tgt_sub_q,
    output logic             trig,
    output logic             hit_flag,
    output logic             irq
);

    tgt_state_t state_q, state_d;
    logic       passed;
    logic       fire;

    assign passed = time_now > {tgt_sec_q, tgt_sub_q};
    assign fire   = (state_q == TGT_ARMED) && passed && !tgt_sec_wr && !tgt_sub_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TGT_DISARMED: if (tgt_sub_wr) state_d = TGT_ARMED;
            TGT_ARMED: begin
                if (tgt_sec_wr)      state_d = TGT_DISARMED;
                else if (tgt_sub_wr) state_d = TGT_ARMED;
                else if (passed)     state_d = TGT_FIRED;
            end
            TGT_FIRED: begin
                if (tgt_sec_wr)      state_d = TGT_DISARMED;
                else if (tgt_sub_wr) state_d = TGT_ARMED;
            end
            default: state_d = TGT_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TGT_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        trig = (state_q == TGT_FIRED);
        irq  = hit_flag && !irq_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_sec_q <= '0;
            tgt_sub_q <= '0;
            hit_flag  <= 1'b0;
        end else begin
            if (tgt_sec_wr) tgt_sec_q <= tgt_sec_in;
            if (tgt_sub_wr) tgt_sub_q <= tgt_sub_in;
            if (fire)           hit_flag <= 1'b1;
            else if (status_rd) hit_flag <= 1'b0;
        end
    end

    AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !tgt_sec_wr && !tgt_sub_wr) |=> trig); // R7

    AST_TRIG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sec_wr || tgt_sub_wr) |=> !trig); // R7

    AST_TRIG_ONLY_PAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> ($past(time_now) > {tgt_sec_q, tgt_sub_q})); // R6

    AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && state_q != TGT_ARMED) |=> !hit_flag); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq); // R9

endmodule

// File: rtl/ptp_clock_corrector.sv
module ptp_clock_corrector
    import ptpc_pkg::*;
#(
    parameter int          SEC_W       = 32,
    parameter int          SUB_W       = 31,
    parameter int          ACC_W       = 32,
    parameter logic [31:0] ADDEND_INIT = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        trig_out,
    output logic        irq
);

    localparam int DW = 32;
    localparam int TW = SEC_W + SUB_W;

    logic             ctrl_wr;
    logic             step_pend, addend_pend;
    logic             do_step, do_addend;
    logic             irq_mask_q;
    logic             step_neg_q;
    logic [SEC_W-1:0] step_sec_q;
    logic [SUB_W-1:0] step_sub_q;
    logic [ACC_W-1:0] addend_stage_q;
    logic [ACC_W-1:0] addend_live;
    logic [TW-1:0]    time_now;
    logic [SEC_W-1:0] tgt_sec;
    logic [SUB_W-1:0] tgt_sub;
    logic             hit_flag;
    logic             tgt_sec_wr, tgt_sub_wr, status_rd;

    assign ctrl_wr    = wr_en && (addr == REG_CTRL);
    assign tgt_sec_wr = wr_en && (addr == REG_TGT_SEC);
    assign tgt_sub_wr = wr_en && (addr == REG_TGT_SUB);
    assign status_rd  = rd_en && (addr == REG_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_mask_q     <= 1'b0;
            step_neg_q     <= 1'b0;
            step_sec_q     <= '0;
            step_sub_q     <= '0;
            addend_stage_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                REG_CTRL:         irq_mask_q <= wdata[CTRL_MASK_BIT];
                REG_STEP_SEC:     step_sec_q <= wdata[SEC_W-1:0];
                REG_STEP_SUB: begin
                    step_neg_q <= wdata[DW-1];
                    step_sub_q <= wdata[SUB_W-1:0];
                end
                REG_ADDEND_STAGE: addend_stage_q <= wdata[ACC_W-1:0];
                default: ;
            endcase
        end
    end

    ptpc_cmd_fsm u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .set_step    (wdata[CTRL_STEP_BIT]),
        .set_addend  (wdata[CTRL_ADDEND_BIT]),
        .step_pend   (step_pend),
        .addend_pend (addend_pend),
        .do_step     (do_step),
        .do_addend   (do_addend)
    );

    ptpc_time_core #(
        .SEC_W       (SEC_W),
        .SUB_W       (SUB_W),
        .ACC_W       (ACC_W),
        .ADDEND_INIT (ADDEND_INIT)
    ) u_time (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_step      (do_step),
        .do_addend    (do_addend),
        .step_neg     (step_neg_q),
        .step_sec     (step_sec_q),
        .step_sub     (step_sub_q),
        .addend_stage (addend_stage_q),
        .time_q       (time_now),
        .addend_q     (addend_live)
    );

    ptpc_target_unit #(
        .SEC_W (SEC_W),
        .SUB_W (SUB_W)
    ) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_now   (time_now),
        .tgt_sec_wr (tgt_sec_wr),
        .tgt_sub_wr (tgt_sub_wr),
        .tgt_sec_in (wdata[SEC_W-1:0]),
        .tgt_sub_in (wdata[SUB_W-1:0]),
        .status_rd  (status_rd),
        .irq_mask   (irq_mask_q),
        .tgt_sec_q  (tgt_sec),
        .tgt_sub_q  (tgt_sub),
        .trig       (trig_out),
        .hit_flag   (hit_flag),
        .irq        (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL:         rdata = DW'({irq_mask_q, addend_pend, step_pend});
            REG_STEP_SEC:     rdata = DW'(step_sec_q);
            REG_STEP_SUB:     rdata = {step_neg_q, (DW-1)'(step_sub_q)};
            REG_ADDEND_STAGE: rdata = DW'(addend_stage_q);
            REG_TGT_SEC:      rdata = DW'(tgt_sec);
            REG_TGT_SUB:      rdata = DW'(tgt_sub);
            REG_TIME_SEC:     rdata = DW'(time_now[TW-1:SUB_W]);
            REG_TIME_SUB:     rdata = DW'(time_now[SUB_W-1:0]);
            REG_STATUS:       rdata = DW'(hit_flag);
            REG_ADDEND_LIVE:  rdata = DW'(addend_live);
            default:          rdata = '0;
        endcase
    end

    AST_STEP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |-> $past(step_pend)); // R2

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hit_flag); // R9

endmodule

// File: tb/ptp_clock_corrector_bench.sv
`timescale 1ns/1ps
module ptp_clock_corrector_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        trig_out;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic mask_sh = 1'b0;

    always #2.5 clk = ~clk;

    ptp_clock_corrector u_ptp_clock_corrector (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_out(trig_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl(input bit step, input bit add);
        wr(4'd0, {29'd0, mask_sh, add, step});
    endtask

    task automatic read_time(output logic [62:0] t);
        logic [31:0] s, u;
        rd(4'd6, s);
        rd(4'd7, u);
        t = {s, u[30:0]};
    endtask

    task automatic set_rate(input logic [31:0] a);
        wr(4'd3, a);
        ctrl(1'b0, 1'b1);
        idle(4);
    endtask

    task automatic step(input logic [62:0] off, input bit neg);
        wr(4'd1, off[62:31]);
        wr(4'd2, {neg, off[30:0]});
        ctrl(1'b1, 1'b0);
        idle(4);
    endtask

    task automatic set_target(input logic [62:0] t);
        wr(4'd4, t[62:31]);
        wr(4'd5, {1'b0, t[30:0]});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 trig", {63'd0, trig_out}, 64'd0);
        chk("R10 irq", {63'd0, irq}, 64'd0);
        rd(4'd6, d); chk("R10 sec", {32'd0, d}, 64'd0);
        rd(4'd9, d); chk("R10 addend", {32'd0, d}, 64'h8000_0000);
        rd(4'd8, d); chk("R10 status", {32'd0, d}, 64'd0);
        rd(4'd0, d); chk("R10 ctrl", {32'd0, d}, 64'd0);
    endtask

    task automatic t_addend();
        logic [31:0] d;
        logic [62:0] t0, t1;
        wr(4'd3, 32'd0);
        idle(3);
        rd(4'd9, d); chk("R4 live unchanged", {32'd0, d}, 64'h8000_0000);
        ctrl(1'b0, 1'b1);
        idle(4);
        rd(4'd9, d); chk("R4 live loaded", {32'd0, d}, 64'd0);
        read_time(t0);
        idle(10);
        read_time(t1);
        chk("R1 frozen at zero addend", {1'b0, t1}, {1'b0, t0});
    endtask

    task automatic t_step_add();
        logic [31:0] d;
        logic [62:0] t0, t1, off;
        read_time(t0);
        off = {32'd7, 31'h7FFF_FFF0};
        wr(4'd1, off[62:31]);
        wr(4'd2, {1'b0, off[30:0]});
        ctrl(1'b1, 1'b0);
        rd(4'd0, d); chk("R3 step pending", {63'd0, d[0]}, 64'd1);
        idle(3);
        rd(4'd0, d); chk("R3 step cleared", {63'd0, d[0]}, 64'd0);
        read_time(t1);
        chk("R2 add with carry", {1'b0, t1}, {1'b0, t0 + off});
    endtask

    task automatic t_step_sub();
        logic [62:0] t0, t1, off;
        read_time(t0);
        off = {32'd2, t0[30:0] + 31'd100};
        step(off, 1'b1);
        read_time(t1);
        chk("R2 subtract with borrow", {1'b0, t1}, {1'b0, t0 - off});
        chk("R2 borrow sub field", {33'd0, t1[30:0]}, {33'd0, 31'h7FFF_FF9C});
    endtask

    task automatic t_rollover();
        logic [62:0] t0, t1, goal;
        read_time(t0);
        goal = {t0[62:31] + 32'd2, 31'h7FFF_FFFF};
        step(goal - t0, 1'b0);
        read_time(t1);
        chk("R1 parked below wrap", {1'b0, t1}, {1'b0, goal});
        set_rate(32'h8000_0000);
        idle(10);
        set_rate(32'd0);
        read_time(t1);
        chk("R1 seconds carried", {32'd0, t1[62:31]}, {32'd0, goal[62:31] + 32'd1});
        chk("R1 sub wrapped small", {63'd0, (t1[30:0] >= 31'd2 && t1[30:0] <= 31'd20)}, 64'd1);
    endtask

    task automatic t_both();
        logic [31:0] d;
        logic [62:0] t0, t1, off;
        read_time(t0);
        off = {32'd1, 31'd5};
        wr(4'd1, off[62:31]);
        wr(4'd2, {1'b0, off[30:0]});
        wr(4'd3, 32'd5);
        ctrl(1'b1, 1'b1);
        idle(4);
        rd(4'd0, d); chk("R5 both cleared", {62'd0, d[1:0]}, 64'd0);
        rd(4'd9, d); chk("R5 addend applied", {32'd0, d}, 64'd5);
        read_time(t1);
        chk("R5 step applied", {1'b0, t1}, {1'b0, t0 + off});
        set_rate(32'd0);
    endtask

    task automatic t_target();
        logic [31:0] d;
        logic [62:0] t0;
        read_time(t0);
        set_target(t0);
        idle(5);
        chk("R6 equal no trigger", {63'd0, trig_out}, 64'd0);
        set_target(t0 - 63'd1);
        idle(2);
        chk("R6 trigger past target", {63'd0, trig_out}, 64'd1);
        chk("R9 irq unmasked", {63'd0, irq}, 64'd1);
        rd(4'd8, d); chk("R8 status set", {32'd0, d}, 64'd1);
        rd(4'd8, d); chk("R8 status cleared by read", {32'd0, d}, 64'd0);
        chk("R9 irq follows clear", {63'd0, irq}, 64'd0);
        idle(5);
        chk("R7 trigger holds", {63'd0, trig_out}, 64'd1);
        wr(4'd4, t0[62:31] + 32'd5);
        chk("R7 seconds write drops", {63'd0, trig_out}, 64'd0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        logic [62:0] t0;
        mask_sh = 1'b1;
        ctrl(1'b0, 1'b0);
        read_time(t0);
        set_target(t0 - 63'd3);
        idle(2);
        chk("R6 fires under mask", {63'd0, trig_out}, 64'd1);
        chk("R9 irq masked", {63'd0, irq}, 64'd0);
        rd(4'd8, d); chk("R8 flag set under mask", {32'd0, d}, 64'd1);
        mask_sh = 1'b0;
        ctrl(1'b0, 1'b0);
        chk("R9 irq stays low after read", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_running();
        logic [62:0] t0;
        read_time(t0);
        set_target(t0 + 63'd3);
        idle(4);
        chk("R6 not yet reached", {63'd0, trig_out}, 64'd0);
        set_rate(32'h8000_0000);
        idle(30);
        chk("R6 reached while running", {63'd0, trig_out}, 64'd1);
        set_rate(32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_addend();
        t_step_add();
        t_step_sub();
        t_rollover();
        t_both();
        t_target();
        t_mask();
        t_running();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule